// File: doc/BRIEF.md
# Masked-Window GPIO Port

This block is one general-purpose I/O port of up to eight pins, placed on a simple register bus with byte addresses. Each pin has four configuration bits: direction, alternate-function select, pull-up and digital enable. The port's output data is reached through a window of 256 words. Address bits [9:2] of an access form a pin mask, so one bus write can set or clear a chosen group of pins without reading the port first. A read through the same window returns only the selected pins. A software task and an interrupt handler can therefore each drive their own pins with no read-modify-write race.

Some pins are protected. Their configuration bits change only through a commit register, and that register accepts writes only after a fixed 32-bit key has been written to the lock register. A clock-enable input stands in for the port's gated clock. A small state machine (CK_OFF, CK_WARM, CK_READY) enforces the settling time after the clock is turned on. The transitions are CK_OFF to CK_WARM when clk_en is high, CK_WARM to CK_READY when clk_en stays high, and any state to CK_OFF when clk_en is low. A second machine (LK_SHUT, LK_OPEN) holds the unlock state. It moves LK_SHUT to LK_OPEN when the key is written to the lock register, and LK_OPEN to LK_SHUT when any other value is written there.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset every configuration register and the output latch read 0, pin_oe and pin_pu are 0, the lock register reads 1 and the commit register reads the inverse of the protected-pin set (0xFE by default, with pin 0 protected).
- R2: A write with address bits [11:10]=00 and [1:0]=00 is a data write. It changes only the output bits whose position is set in address bits [9:2]. Byte offset 0x044 selects pins 4 and 0, and 0x3FC selects all eight pins.
- R3: A data read returns, in each selected position, the output latch for a digitally enabled pin that is a plain GPIO output, pin_in for any other digitally enabled pin, and 0 for a pin that is not digitally enabled. Unselected positions read 0.
- R4: pin_oe for a pin is 1 only when its digital-enable bit is set and either it is a plain GPIO pin with direction 1 (output) or it is an alternate-function pin whose alt_oe is 1. Direction 0 makes the pin an input.
- R5: A pin whose alternate-select bit is 1 takes pin_out and its enable from alt_out and alt_oe. Select 0 means plain GPIO.
- R6: pin_pu follows the pull-up register, with 1 enabling the pull-up.
- R7: The configuration registers are direction at 0x400, alternate select at 0x404, pull-up at 0x408 and digital enable at 0x40C. A write to one of them leaves unchanged every bit whose commit bit is 0. Writing the key 0xC0DE5AFE to the lock register (0x410) makes it read 0, and any other value makes it read 1 again. The commit register (0x414) takes writes only while the lock register reads 0, and its unprotected bits always read 1.
- R8: While clk_en is low, and during the first two clock edges after clk_en goes high, writes are ignored and every read returns 0. An access at the third edge takes effect.
- R9: Reads of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Port clock enable |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pin input levels |
| alt_out | input | 8 | Output values from the alternate function |
| alt_oe | input | 8 | Output enables from the alternate function |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| pin_pu | output | 8 | Pull-up enables |

## Verification
The bench writes through partial masks, such as pins 4 and 0 or pins 3 and 2, over an established pattern. A design that ignored the address mask would overwrite the other pins, and one that decoded the mask from the wrong address bits would change the wrong pins. Masked reads are taken with the pins set to a mix of inputs, outputs, alternate-function pins and a disabled pin. This exposes a design that returns the output latch for input pins, leaks unselected bits, or reports a disabled pin. The lock sequence tries a commit write while locked, a wrong key, the correct key, and then relocking. A design with a weak key check or unguarded commit bits would let protected pin 0 be reconfigured. The clock-enable tests write during the two settling edges and while the clock is off. A design with a short or missing warm-up would accept those writes or return non-zero reads.

// File: rtl/gpm_pkg.sv
`timescale 1ns/1ps
package gpm_pkg;
    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;
    localparam int N_CFG  = 4;

    // Index of each configuration register inside the config bank
    localparam int CFG_DIR  = 0;
    localparam int CFG_ALT  = 1;
    localparam int CFG_PULL = 2;
    localparam int CFG_DEN  = 3;

    // Word index (address bits [9:2]) inside the control page (bits [11:10] = 01)
    localparam logic [7:0] W_DIR    = 8'h00;
    localparam logic [7:0] W_ALT    = 8'h01;
    localparam logic [7:0] W_PULL   = 8'h02;
    localparam logic [7:0] W_DEN    = 8'h03;
    localparam logic [7:0] W_LOCK   = 8'h04;
    localparam logic [7:0] W_COMMIT = 8'h05;

    typedef enum logic [1:0] {CK_OFF, CK_WARM, CK_READY} ck_state_t;
    typedef enum logic       {LK_SHUT, LK_OPEN} lk_state_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_DATA, SEL_DIR, SEL_ALT, SEL_PULL, SEL_DEN, SEL_LOCK, SEL_COMMIT
    } sel_t;
endpackage

// File: rtl/gpm_clk_fsm.sv
`timescale 1ns/1ps
module gpm_clk_fsm
    import gpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic acc_ok
);
    ck_state_t state_q;
    ck_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_OFF:   state_d = clk_en ? CK_WARM  : CK_OFF;
            CK_WARM:  state_d = clk_en ? CK_READY : CK_OFF;
            CK_READY: state_d = clk_en ? CK_READY : CK_OFF;
            default:  state_d = CK_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CK_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        acc_ok = (state_q == CK_READY) && clk_en;
    end

    AST_READY_AFTER_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_ok) |-> ($past(clk_en, 1) && $past(clk_en, 2))); // R8
endmodule

// File: rtl/gpm_lock_fsm.sv
`timescale 1ns/1ps
module gpm_lock_fsm
    import gpm_pkg::*;
#(
    parameter int                N_PINS     = 8,
    parameter logic [N_PINS-1:0] PROT_PINS  = 8'h01,
    parameter logic [31:0]       UNLOCK_KEY = 32'hC0DE_5AFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic              commit_wr,
    input  logic [31:0]       wdata,
    output logic              is_open,
    output logic [N_PINS-1:0] commit
);
    lk_state_t         state_q;
    lk_state_t         state_d;
    logic [N_PINS-1:0] commit_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (lock_wr && (wdata == UNLOCK_KEY)) state_d = LK_OPEN;
            LK_OPEN: if (lock_wr && (wdata != UNLOCK_KEY)) state_d = LK_SHUT;
            default: state_d = LK_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            commit_q <= ~PROT_PINS;
        else if (commit_wr && (state_q == LK_OPEN))
            commit_q <= wdata[N_PINS-1:0] | ~PROT_PINS;
    end

    always_comb begin
        is_open = (state_q == LK_OPEN);
        commit  = commit_q;
    end

    AST_COMMIT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(commit_q) |-> $past(state_q == LK_OPEN)); // R7
    AST_OPEN_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> $past(lock_wr && (wdata == UNLOCK_KEY))); // R7
endmodule

// File: rtl/gpm_cfg_bank.sv
`timescale 1ns/1ps
module gpm_cfg_bank
    import gpm_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_idx,
    input  logic              out_wr,
    input  logic [N_PINS-1:0] mask,
    input  logic [N_PINS-1:0] wdata,
    input  logic [N_PINS-1:0] commit,
    output logic [N_PINS-1:0] cfg_dir,
    output logic [N_PINS-1:0] cfg_alt,
    output logic [N_PINS-1:0] cfg_pull,
    output logic [N_PINS-1:0] cfg_den,
    output logic [N_PINS-1:0] out_q
);
    logic [N_CFG-1:0][N_PINS-1:0] cfg_q;

    for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (cfg_wr && (cfg_idx == g[1:0]))
                cfg_q[g] <= (cfg_q[g] & ~commit) | (wdata & commit);
        end

        AST_PROTECTED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_wr |=> (((cfg_q[g] ^ $past(cfg_q[g])) & ~$past(commit)) == '0)); // R7
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out_q <= '0;
        else if (out_wr) out_q <= (out_q & ~mask) | (wdata & mask);
    end

    always_comb begin
        cfg_dir  = cfg_q[CFG_DIR];
        cfg_alt  = cfg_q[CFG_ALT];
        cfg_pull = cfg_q[CFG_PULL];
        cfg_den  = cfg_q[CFG_DEN];
    end

    AST_MASK_LIMITS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0)); // R2
    AST_DATA_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr |=> $stable(out_q)); // R2
endmodule

// File: rtl/gpio_masked_port.sv
`timescale 1ns/1ps
module gpio_masked_port
    import gpm_pkg::*;
#(
    parameter int                N_PINS     = 8,
    parameter logic [N_PINS-1:0] PROT_PINS  = 8'h01,
    parameter logic [31:0]       UNLOCK_KEY = 32'hC0DE_5AFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] alt_out,
    input  logic [N_PINS-1:0] alt_oe,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_pu
);
    sel_t              sel;
    logic              acc_ok;
    logic              wr_ok;
    logic              cfg_wr;
    logic [1:0]        cfg_idx;
    logic [N_PINS-1:0] mask;
    logic              is_open;
    logic [N_PINS-1:0] commit;
    logic [N_PINS-1:0] cfg_dir, cfg_alt, cfg_pull, cfg_den, out_q;
    logic [N_PINS-1:0] data_view;

    // Address decode
    always_comb begin
        sel = SEL_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr[11:10] == 2'b00) begin
                sel = SEL_DATA;
            end else if (bus_addr[11:10] == 2'b01) begin
                case (bus_addr[9:2])
                    W_DIR:    sel = SEL_DIR;
                    W_ALT:    sel = SEL_ALT;
                    W_PULL:   sel = SEL_PULL;
                    W_DEN:    sel = SEL_DEN;
                    W_LOCK:   sel = SEL_LOCK;
                    W_COMMIT: sel = SEL_COMMIT;
                    default:  sel = SEL_NONE;
                endcase
            end
        end
    end

    always_comb begin
        mask    = bus_addr[2 +: N_PINS];
        wr_ok   = bus_we && acc_ok;
        cfg_wr  = wr_ok && (sel inside {SEL_DIR, SEL_ALT, SEL_PULL, SEL_DEN});
        unique case (sel)
            SEL_ALT:  cfg_idx = 2'(CFG_ALT);
            SEL_PULL: cfg_idx = 2'(CFG_PULL);
            SEL_DEN:  cfg_idx = 2'(CFG_DEN);
            default:  cfg_idx = 2'(CFG_DIR);
        endcase
    end

    gpm_clk_fsm u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .acc_ok (acc_ok)
    );

    gpm_lock_fsm #(
        .N_PINS     (N_PINS),
        .PROT_PINS  (PROT_PINS),
        .UNLOCK_KEY (UNLOCK_KEY)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_wr   (wr_ok && (sel == SEL_LOCK)),
        .commit_wr (wr_ok && (sel == SEL_COMMIT)),
        .wdata     (bus_wdata),
        .is_open   (is_open),
        .commit    (commit)
    );

    gpm_cfg_bank #(.N_PINS(N_PINS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_idx  (cfg_idx),
        .out_wr   (wr_ok && (sel == SEL_DATA)),
        .mask     (mask),
        .wdata    (bus_wdata[N_PINS-1:0]),
        .commit   (commit),
        .cfg_dir  (cfg_dir),
        .cfg_alt  (cfg_alt),
        .cfg_pull (cfg_pull),
        .cfg_den  (cfg_den),
        .out_q    (out_q)
    );

    // Per-pin steering between GPIO and alternate function
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        assign pin_out[g]   = cfg_alt[g] ? alt_out[g] : out_q[g];
        assign pin_oe[g]    = cfg_den[g] & (cfg_alt[g] ? alt_oe[g] : cfg_dir[g]);
        assign data_view[g] = cfg_den[g] &
                              ((cfg_dir[g] & ~cfg_alt[g]) ? out_q[g] : pin_in[g]);
    end

    assign pin_pu = cfg_pull;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (acc_ok) begin
            unique case (sel)
                SEL_DATA:   bus_rdata[N_PINS-1:0] = data_view & mask;
                SEL_DIR:    bus_rdata[N_PINS-1:0] = cfg_dir;
                SEL_ALT:    bus_rdata[N_PINS-1:0] = cfg_alt;
                SEL_PULL:   bus_rdata[N_PINS-1:0] = cfg_pull;
                SEL_DEN:    bus_rdata[N_PINS-1:0] = cfg_den;
                SEL_LOCK:   bus_rdata[0]          = ~is_open;
                SEL_COMMIT: bus_rdata[N_PINS-1:0] = commit;
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_GATED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |=> ($stable(cfg_den) && $stable(cfg_dir) && $stable(pin_pu)
                     && $stable(commit))); // R8
    AST_GATED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ok |-> (bus_rdata == '0)); // R8
endmodule

// File: tb/sim_gpio_masked_port.sv
`timescale 1ns/1ps
module sim_gpio_masked_port;
    localparam logic [31:0] KEY = 32'hC0DE_5AFE;
    localparam logic [11:0] A_DIR = 12'h400, A_ALT = 12'h404, A_PULL = 12'h408,
                            A_DEN = 12'h40C, A_LOCK = 12'h410, A_COMMIT = 12'h414;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0, alt_out = '0, alt_oe = '0;
    logic [7:0]  pin_out, pin_oe, pin_pu;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_masked_port u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .alt_out(alt_out),
        .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input string what,
                          input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(req, what, bus_rdata, exp);
    endtask

    task automatic t_reset_pins;
        chk("R1", "pin_oe after reset", {24'h0, pin_oe}, 32'h0);
        chk("R1", "pin_pu after reset", {24'h0, pin_pu}, 32'h0);
        chk("R1", "pin_out after reset", {24'h0, pin_out}, 32'h0);
    endtask

    task automatic t_warmup;
        @(negedge clk);
        clk_en = 1'b1;
        bus_addr = A_DEN; bus_wdata = 32'hFF; bus_we = 1'b1;
        #1 chk("R8", "read before first edge", bus_rdata, 32'h0);
        @(negedge clk);
        #1 chk("R8", "read after first edge", bus_rdata, 32'h0);
        @(negedge clk);
        bus_we = 1'b0;
        rd_chk("R8", "warm-up writes ignored", A_DEN, 32'h0);
    endtask

    task automatic t_reset_regs;
        rd_chk("R1", "dir after reset", A_DIR, 32'h0);
        rd_chk("R1", "alt after reset", A_ALT, 32'h0);
        rd_chk("R1", "lock after reset", A_LOCK, 32'h1);
        rd_chk("R1", "commit after reset", A_COMMIT, 32'hFE);
        rd_chk("R1", "data after reset", 12'h3FC, 32'h0);
        rd_chk("R9", "unmapped read", 12'h500, 32'h0);
        rd_chk("R9", "misaligned read", 12'h401, 32'h0);
    endtask

    task automatic t_config;
        bus_wr(A_DEN, 32'h0F);
        rd_chk("R7", "den bit0 protected", A_DEN, 32'h0E);
        bus_wr(A_DIR, 32'hF1);
        rd_chk("R7", "dir bit0 protected", A_DIR, 32'hF0);
        #1 chk("R4", "oe off without den", {24'h0, pin_oe}, 32'h0);
        bus_wr(A_DEN, 32'hFF);
        #1 chk("R4", "oe = den & dir", {24'h0, pin_oe}, 32'hF0);
        bus_wr(A_PULL, 32'h3C);
        #1 chk("R6", "pull-up follows reg", {24'h0, pin_pu}, 32'h3C);
    endtask

    task automatic t_masked_write;
        bus_wr(12'h3FC, 32'h00);
        bus_wr(12'h044, 32'hFF);
        #1 chk("R2", "mask pins 4,0", {24'h0, pin_out}, 32'h11);
        bus_wr(12'h3FC, 32'hA5);
        #1 chk("R2", "full mask write", {24'h0, pin_out}, 32'hA5);
        bus_wr(12'h030, 32'h00);
        #1 chk("R2", "mask pins 3,2 clear", {24'h0, pin_out}, 32'hA1);
        bus_wr(12'h000, 32'hFF);
        #1 chk("R2", "empty mask no change", {24'h0, pin_out}, 32'hA1);
    endtask

    task automatic t_masked_read;
        pin_in = 8'h5A;
        rd_chk("R3", "full read mixed pins", 12'h3FC, 32'hAA);
        rd_chk("R3", "read pins 5,3", 12'h0A0, 32'h28);
        rd_chk("R3", "read empty mask", 12'h000, 32'h0);
    endtask

    task automatic t_alt;
        alt_out = 8'h10; alt_oe = 8'h10;
        bus_wr(A_ALT, 32'h30);
        #1 chk("R5", "pin_out from alt", {24'h0, pin_out}, 32'h91);
        chk("R5", "pin_oe from alt_oe", {24'h0, pin_oe}, 32'hD0);
        rd_chk("R5", "alt pins read pin_in", 12'h0C0, 32'h10);
    endtask

    task automatic t_lock;
        rd_chk("R7", "locked", A_LOCK, 32'h1);
        bus_wr(A_COMMIT, 32'hFF);
        rd_chk("R7", "commit while locked", A_COMMIT, 32'hFE);
        bus_wr(A_LOCK, 32'h1234_5678);
        rd_chk("R7", "wrong key", A_LOCK, 32'h1);
        bus_wr(A_LOCK, KEY);
        rd_chk("R7", "key unlocks", A_LOCK, 32'h0);
        bus_wr(A_COMMIT, 32'hFF);
        rd_chk("R7", "commit while open", A_COMMIT, 32'hFF);
        bus_wr(A_DEN, 32'hFF);
        rd_chk("R7", "den bit0 now writable", A_DEN, 32'hFF);
        bus_wr(A_LOCK, 32'h0);
        rd_chk("R7", "relocked", A_LOCK, 32'h1);
        bus_wr(A_COMMIT, 32'h00);
        rd_chk("R7", "commit held after relock", A_COMMIT, 32'hFF);
    endtask

    task automatic t_gate_off;
        @(negedge clk);
        clk_en = 1'b0;
        rd_chk("R8", "read while off", A_DIR, 32'h0);
        bus_wr(A_DIR, 32'h00);
        #1 chk("R8", "oe held while off", {24'h0, pin_oe}, 32'hD0);
        @(negedge clk);
        clk_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R8", "write while off ignored", A_DIR, 32'hF0);
    endtask

    initial begin
        #(8 * 60000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_pins();
        t_warmup();
        t_reset_regs();
        t_config();
        t_masked_write();
        t_masked_read();
        t_alt();
        t_lock();
        t_gate_off();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule